// File: doc/BRIEF.md
# Block-Granular Reorder Sequencer

This block keeps program order for a core that executes code in atomic blocks of several instructions rather than one instruction at a time. The dispatch stage asks it for a tag each time it sends a block to an execution backend. Tags are handed out in program order from a small circular window. Backends report events against a tag: the block finished, a branch at the block's exit went the wrong way, a branch inside the block went the wrong way, or an instruction in the block faulted. A block whose results are complete leaves the window through the retire port, oldest first and one per cycle. Its results commit as a whole.

A misprediction at a block's exit keeps that block and discards every younger one. A misprediction inside a block, or a fault, discards the block itself together with everything younger. The discard is announced one cycle later on the squash port, with the oldest tag that was dropped. A fault also moves the sequencer into replay mode. In that mode the front end steps through the faulting code one instruction at a time, and no new block is accepted. Replay mode ends when the front end signals that the faulting instruction has been reached.

Top module: `blk_rob_seq`

## Requirements
- R1: After reset, tags are given out as 0, 1, 2, ... and wrap modulo DEPTH. `alloc_tag_o` always shows the tag that the next accepted allocation will receive.
- R2: `alloc_ready_o` is low while DEPTH blocks are outstanding. An allocation request made while it is low has no effect.
- R3: Blocks retire strictly in allocation order, at most one per cycle. The retired tags form an unbroken sequence modulo DEPTH, with `ret_tag_o` always naming the oldest outstanding block.
- R4: A block retires in the cycle after its completion is reported (kind 2'b00, or kind 2'b01), provided it is the oldest block. Until then, younger completed blocks wait.
- R5: An exit misprediction (kind 2'b01) marks the block complete and drops every younger block. One cycle later `sq_valid_o` pulses with `sq_tag_o` = tag+1 and `sq_fault_o` = 0, and the next allocation receives tag+1.
- R6: An inner misprediction (kind 2'b10) drops the block itself and every younger block. `sq_tag_o` equals the tag, the next allocation reuses that tag, and replay mode is not entered.
- R7: A fault (kind 2'b11) drops the block and every younger block, pulses the squash port with `sq_fault_o` = 1, and raises `replay_o` from the next cycle. While `replay_o` is high, `alloc_ready_o` is low.
- R8: `replay_done_i` clears `replay_o` on the next cycle. When replay mode is not active, it has no effect.
- R9: A kind 2'b10 or 2'b11 event on the oldest block stops that block from retiring in the same cycle, even if it is already complete. A retirement and a squash of younger blocks can both happen in one cycle.
- R10: An event naming a tag that is not outstanding has no effect: no squash, no mode change, no completion.
- R11: After reset the window is empty, `alloc_ready_o` = 1, `ret_valid_o` = 0, `sq_valid_o` = 0 and `replay_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid_i | input | 1 | Dispatch requests a tag for a new block |
| alloc_ready_o | output | 1 | A tag can be taken this cycle |
| alloc_tag_o | output | TAG_W | Tag the next accepted block receives |
| evt_valid_i | input | 1 | Backend event present |
| evt_tag_i | input | TAG_W | Block the event refers to |
| evt_kind_i | input | 2 | 00 done, 01 exit mispredict, 10 inner mispredict, 11 fault |
| replay_done_i | input | 1 | Faulting instruction reached during replay |
| ret_valid_o | output | 1 | Oldest block commits this cycle |
| ret_tag_o | output | TAG_W | Tag of the oldest outstanding block |
| sq_valid_o | output | 1 | Squash pulse |
| sq_tag_o | output | TAG_W | Oldest dropped tag |
| sq_fault_o | output | 1 | Squash was caused by a fault |
| replay_o | output | 1 | Single-instruction replay mode is active |

## Verification
Retirement of the oldest block and a squash caused by an event in the same cycle are the interaction that matters most. The bench provokes it in two ways. In one, the oldest block is already complete when an exit misprediction hits a younger block. In the other, a fault or inner misprediction hits that complete oldest block directly. In the first case both the commit and the cut of the younger blocks must be seen. In the second, the commit must be withheld and the squash must name the oldest block. A behavioural model of the window in the bench recomputes the retire, allocation and squash outputs on every clock, and the bench compares them with the design's outputs.

// File: rtl/blk_rob_pkg.sv
// Shared types of the block reorder sequencer.
// Assumes: event kinds are encoded on two bits as listed below.
package blk_rob_pkg;
    typedef enum logic [1:0] {
        EV_DONE       = 2'b00,
        EV_MISP_EDGE  = 2'b01,
        EV_MISP_INNER = 2'b10,
        EV_FAULT      = 2'b11
    } evt_kind_e;
endpackage

// File: rtl/blk_rob_ptr.sv
// Head, tail and occupancy of the circular block window.
// On a cut, the tail is rebuilt as head + keep and the count as keep minus any
// retirement in the same cycle. Assumes DEPTH is a power of two and that push
// and cut are never raised together.
module blk_rob_ptr #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             cut_i,
    input  logic [CNT_W-1:0] keep_i,
    output logic [TAG_W-1:0] head_o,
    output logic [TAG_W-1:0] tail_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o
);
    logic [TAG_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;

    // Advance the pointers on push/pop, or rebuild them on a cut.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (cut_i) begin
            head_q  <= head_q + TAG_W'(pop_i);
            tail_q  <= head_q + TAG_W'(keep_i);
            count_q <= keep_i - CNT_W'(pop_i);
        end else begin
            head_q  <= head_q + TAG_W'(pop_i);
            tail_q  <= tail_q + TAG_W'(push_i);
            count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
        end
    end

    assign head_o  = head_q;
    assign tail_o  = tail_q;
    assign count_o = count_q;
    assign full_o  = (count_q == CNT_W'(DEPTH));
endmodule

// File: rtl/blk_rob_flags.sv
// Per-entry flags: the entry is live (outstanding) and the entry is done.
// An entry is killed by a cut when its distance from the head is at least keep.
// Assumes a push never targets an entry that is live.
module blk_rob_flags #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] head_i,
    input  logic [TAG_W-1:0] tail_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             cut_i,
    input  logic [CNT_W-1:0] keep_i,
    input  logic             mark_i,
    input  logic [TAG_W-1:0] mark_tag_i,
    output logic [DEPTH-1:0] live_o,
    output logic [DEPTH-1:0] done_o
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [TAG_W-1:0] age;
        logic             killed;
        logic             live_q, done_q;

        // Distance of this entry from the oldest one, and cut membership.
        always_comb begin
            age    = TAG_W'(i) - head_i;
            killed = cut_i && (CNT_W'(age) >= keep_i);
        end

        // Set on allocation, mark done on report, clear on retire or kill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q <= 1'b0;
                done_q <= 1'b0;
            end else if (push_i && tail_i == TAG_W'(i)) begin
                live_q <= 1'b1;
                done_q <= 1'b0;
            end else begin
                if (mark_i && mark_tag_i == TAG_W'(i)) done_q <= 1'b1;
                if (killed || (pop_i && head_i == TAG_W'(i))) live_q <= 1'b0;
            end
        end

        assign live_o[i] = live_q;
        assign done_o[i] = done_q;
    end
endmodule

// File: rtl/blk_rob_mode.sv
// Replay-mode state and the registered squash report.
// A fault sets replay mode and wins over a same-cycle replay_done_i. The squash
// report is a one-cycle pulse that follows the cutting event.
module blk_rob_mode #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_take_i,
    input  logic             replay_done_i,
    input  logic             cut_i,
    input  logic [TAG_W-1:0] cut_tag_i,
    output logic             replay_o,
    output logic             sq_valid_o,
    output logic [TAG_W-1:0] sq_tag_o,
    output logic             sq_fault_o
);
    logic             replay_q, sq_valid_q, sq_fault_q;
    logic [TAG_W-1:0] sq_tag_q;

    // Enter replay on a fault, leave it when the fault point is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)              replay_q <= 1'b0;
        else if (fault_take_i)   replay_q <= 1'b1;
        else if (replay_done_i)  replay_q <= 1'b0;
    end

    // Register the squash report for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_valid_q <= 1'b0;
            sq_tag_q   <= '0;
            sq_fault_q <= 1'b0;
        end else begin
            sq_valid_q <= cut_i;
            sq_tag_q   <= cut_i ? cut_tag_i : sq_tag_q;
            sq_fault_q <= cut_i && fault_take_i;
        end
    end

    assign replay_o   = replay_q;
    assign sq_valid_o = sq_valid_q;
    assign sq_tag_o   = sq_tag_q;
    assign sq_fault_o = sq_fault_q;
endmodule

// File: rtl/blk_rob_seq.sv
// Block-granular reorder sequencer top.
// Decodes backend events against the live window, decides retirement of the
// oldest block and the keep length of a cut, and gates allocation.
// Assumes: one event per cycle, DEPTH a power of two.
module blk_rob_seq
    import blk_rob_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid_i,
    output logic             alloc_ready_o,
    output logic [TAG_W-1:0] alloc_tag_o,
    input  logic             evt_valid_i,
    input  logic [TAG_W-1:0] evt_tag_i,
    input  logic [1:0]       evt_kind_i,
    input  logic             replay_done_i,
    output logic             ret_valid_o,
    output logic [TAG_W-1:0] ret_tag_o,
    output logic             sq_valid_o,
    output logic [TAG_W-1:0] sq_tag_o,
    output logic             sq_fault_o,
    output logic             replay_o
);
    logic [TAG_W-1:0] head, tail, evt_age, cut_tag;
    logic [CNT_W-1:0] count, keep;
    logic [DEPTH-1:0] live, done;
    logic             full, evt_hit, cut, kill_head, retire, push, mark, fault_take;
    evt_kind_e        kind;

    // Classify the incoming event and size the surviving part of the window.
    always_comb begin
        kind       = evt_kind_e'(evt_kind_i);
        evt_hit    = evt_valid_i && live[evt_tag_i];
        evt_age    = evt_tag_i - head;
        cut        = evt_hit && (kind != EV_DONE);
        keep       = (kind == EV_MISP_EDGE) ? CNT_W'(evt_age) + CNT_W'(1) : CNT_W'(evt_age);
        kill_head  = cut && (kind != EV_MISP_EDGE) && (evt_tag_i == head);
        mark       = evt_hit && (kind == EV_DONE || kind == EV_MISP_EDGE);
        fault_take = evt_hit && (kind == EV_FAULT);
        cut_tag    = head + TAG_W'(keep);
    end

    // Retirement of the oldest block and acceptance of a new one.
    always_comb begin
        retire        = live[head] && done[head] && !kill_head;
        alloc_ready_o = !full && !replay_o && !cut;
        push          = alloc_valid_i && alloc_ready_o;
    end

    blk_rob_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (retire),
        .cut_i   (cut),
        .keep_i  (keep),
        .head_o  (head),
        .tail_o  (tail),
        .count_o (count),
        .full_o  (full)
    );

    blk_rob_flags #(.DEPTH(DEPTH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_i     (head),
        .tail_i     (tail),
        .push_i     (push),
        .pop_i      (retire),
        .cut_i      (cut),
        .keep_i     (keep),
        .mark_i     (mark),
        .mark_tag_i (evt_tag_i),
        .live_o     (live),
        .done_o     (done)
    );

    blk_rob_mode #(.DEPTH(DEPTH)) u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .fault_take_i  (fault_take),
        .replay_done_i (replay_done_i),
        .cut_i         (cut),
        .cut_tag_i     (cut_tag),
        .replay_o      (replay_o),
        .sq_valid_o    (sq_valid_o),
        .sq_tag_o      (sq_tag_o),
        .sq_fault_o    (sq_fault_o)
    );

    assign alloc_tag_o = tail;
    assign ret_valid_o = retire;
    assign ret_tag_o   = head;
endmodule

// File: rtl/blk_rob_seq_chk.sv
// Property checker for blk_rob_seq, bound to every instance of the top.
// Tracks the last retired tag with its own register.
module blk_rob_seq_chk #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ready_o,
    input logic             evt_valid_i,
    input logic [TAG_W-1:0] evt_tag_i,
    input logic [1:0]       evt_kind_i,
    input logic             replay_done_i,
    input logic             ret_valid_o,
    input logic [TAG_W-1:0] ret_tag_o,
    input logic             sq_valid_o,
    input logic             replay_o,
    input logic [CNT_W-1:0] count,
    input logic [DEPTH-1:0] live
);
    logic             seen_q;
    logic [TAG_W-1:0] last_q;

    // Remember the most recently retired tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (ret_valid_o) begin
            seen_q <= 1'b1;
            last_q <= ret_tag_o;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R2
    AST_FULL_BLOCKS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH)) |-> !alloc_ready_o); // R2
    AST_RET_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_o && seen_q) |-> (ret_tag_o == last_q + TAG_W'(1))); // R3
    AST_KILLED_HEAD_NO_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && evt_kind_i[1] && live[evt_tag_i] && evt_tag_i == ret_tag_o) |-> !ret_valid_o); // R9
    AST_FAULT_ENTERS_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && evt_kind_i == 2'b11 && live[evt_tag_i]) |=> replay_o); // R7
    AST_REPLAY_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        replay_o |-> !alloc_ready_o); // R7
    AST_SQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid_o |-> $past(evt_valid_i)); // R5
    AST_REPLAY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_o && replay_done_i && !(evt_valid_i && evt_kind_i == 2'b11)) |=> !replay_o); // R8
endmodule

bind blk_rob_seq blk_rob_seq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_ready_o (alloc_ready_o),
    .evt_valid_i   (evt_valid_i),
    .evt_tag_i     (evt_tag_i),
    .evt_kind_i    (evt_kind_i),
    .replay_done_i (replay_done_i),
    .ret_valid_o   (ret_valid_o),
    .ret_tag_o     (ret_tag_o),
    .sq_valid_o    (sq_valid_o),
    .replay_o      (replay_o),
    .count         (count),
    .live          (live)
);

// File: tb/blk_rob_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural model of the block window, compared on every clock.
module blk_rob_seq_tb_top;
    localparam int D = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_valid_i = 1'b0, evt_valid_i = 1'b0, replay_done_i = 1'b0;
    logic [2:0] evt_tag_i = '0;
    logic [1:0] evt_kind_i = '0;
    logic       alloc_ready_o, ret_valid_o, sq_valid_o, sq_fault_o, replay_o;
    logic [2:0] alloc_tag_o, ret_tag_o, sq_tag_o;

    int checks = 0;
    int errors = 0;

    // Model state
    bit m_live[D];
    bit m_done[D];
    int m_head = 0, m_cnt = 0;
    bit m_replay = 0, m_sqv = 0, m_sqf = 0;
    int m_sqt = 0;

    always #2.5 clk = ~clk;

    blk_rob_seq #(.DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid_i), .alloc_ready_o(alloc_ready_o), .alloc_tag_o(alloc_tag_o),
        .evt_valid_i(evt_valid_i), .evt_tag_i(evt_tag_i), .evt_kind_i(evt_kind_i),
        .replay_done_i(replay_done_i),
        .ret_valid_o(ret_valid_o), .ret_tag_o(ret_tag_o),
        .sq_valid_o(sq_valid_o), .sq_tag_o(sq_tag_o), .sq_fault_o(sq_fault_o),
        .replay_o(replay_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive, compare against the model, then advance the model.
    task automatic step(input bit av, input bit ev, input int et, input int ek,
                        input bit rd, input string req);
        bit hit, cut, killh, ret, rdy, push;
        int age, keep;
        @(negedge clk);
        alloc_valid_i = av; evt_valid_i = ev; evt_tag_i = 3'(et);
        evt_kind_i = 2'(ek); replay_done_i = rd;
        hit   = ev && m_live[et];
        cut   = hit && ek != 0;
        age   = (et - m_head + D) % D;
        keep  = (ek == 1) ? age + 1 : age;
        killh = cut && ek != 1 && et == m_head;
        ret   = m_cnt > 0 && m_live[m_head] && m_done[m_head] && !killh;
        rdy   = m_cnt < D && !m_replay && !cut;
        push  = av && rdy;
        #1;
        chk(req, "alloc_ready", int'(alloc_ready_o), int'(rdy));
        chk(req, "alloc_tag", int'(alloc_tag_o), (m_head + m_cnt) % D);
        chk(req, "ret_valid", int'(ret_valid_o), int'(ret));
        if (m_cnt > 0) chk(req, "ret_tag", int'(ret_tag_o), m_head);
        chk(req, "sq_valid", int'(sq_valid_o), int'(m_sqv));
        if (m_sqv) begin
            chk(req, "sq_tag", int'(sq_tag_o), m_sqt);
            chk(req, "sq_fault", int'(sq_fault_o), int'(m_sqf));
        end
        chk(req, "replay", int'(replay_o), int'(m_replay));
        @(posedge clk);
        m_sqv = cut; m_sqf = cut && ek == 3;
        if (cut) m_sqt = (m_head + keep) % D;
        if (hit && (ek == 0 || ek == 1)) m_done[et] = 1;
        if (cut) begin
            for (int k = 0; k < D; k++)
                if ((k - m_head + D) % D >= keep) m_live[k] = 0;
        end else if (push) begin
            m_live[(m_head + m_cnt) % D] = 1;
            m_done[(m_head + m_cnt) % D] = 0;
            m_cnt++;
        end
        if (cut) m_cnt = keep;
        if (ret) begin
            m_live[m_head] = 0;
            m_head = (m_head + 1) % D;
            m_cnt--;
        end
        if (hit && ek == 3) m_replay = 1;
        else if (rd) m_replay = 0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int k = 0; k < D; k++) begin m_live[k] = 0; m_done[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R11");                       // reset state
        for (int k = 0; k < 8; k++) step(1, 0, 0, 0, 0, "R1"); // tags 0..7
        step(1, 0, 0, 0, 0, "R2");                         // full: refused
        step(0, 1, 2, 0, 0, "R4");                         // younger done, no retire
        step(0, 1, 1, 0, 0, "R4");
        step(0, 1, 0, 0, 0, "R4");                         // oldest done
        step(0, 0, 0, 0, 0, "R3");                         // retire 0
        step(0, 0, 0, 0, 0, "R3");                         // retire 1
        step(0, 0, 0, 0, 0, "R3");                         // retire 2
        step(0, 1, 1, 0, 0, "R10");                        // stale tag done
        step(0, 1, 1, 3, 0, "R10");                        // stale tag fault
        step(0, 0, 0, 0, 0, "R10");
        step(0, 1, 3, 0, 0, "R9");                         // oldest (3) done
        step(0, 1, 5, 1, 0, "R9");                         // retire 3 + cut 6,7
        step(0, 0, 0, 0, 0, "R5");                         // squash report
        step(1, 0, 0, 0, 0, "R5");                         // next tag 6
        step(0, 1, 6, 2, 0, "R6");                         // inner mispredict on 6
        step(0, 0, 0, 0, 0, "R6");
        step(1, 0, 0, 0, 0, "R6");                         // tag 6 reused
        step(0, 1, 4, 0, 0, "R4");
        step(0, 0, 0, 0, 0, "R3");                         // retire 4, 5
        step(0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 1, "R8");                         // done outside replay
        step(1, 0, 0, 0, 0, "R1");                         // tag 7
        step(1, 0, 0, 0, 0, "R1");                         // tag 0 (wrap)
        step(0, 1, 6, 0, 0, "R7");                         // 6 done
        step(0, 1, 6, 3, 0, "R9");                         // fault on complete oldest
        step(1, 0, 0, 0, 0, "R7");                         // replay: refused
        step(1, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 1, "R8");                         // leave replay
        step(1, 0, 0, 0, 0, "R8");                         // tag 6 again
        step(0, 1, 6, 2, 0, "R6");
        step(0, 0, 0, 0, 0, "R6");
        finish_run();
    end
endmodule